// File: doc/BRIEF.md
# Block-Wise Adaptive Exposure Controller

This block decides, for a pixel array cut into rectangular blocks, when each block stops integrating light. Every pixel holds a digital level that starts at the top of the signal range and drops each cycle by its own photocurrent sample. For each block the controller keeps a running total of the charge drawn by all of its pixels. That total stands for the block's average level. When the average has fallen to the middle of the range, the whole block freezes on the same cycle. As a result, bright blocks close early and dark blocks keep integrating.

The partition is set by two link vectors. One bit joins a pair of adjacent columns, and the other vector joins pairs of adjacent rows. A global cycle limit, chosen to suit the frame rate, closes any block that is still open. After each frame the block reports the frozen pixel levels. For every pixel it also gives the integration time of that pixel's block and whether the block stopped on the mid-range test or on the limit.

Top module: `exp_block_ctl`

## Requirements
- R1: After reset, `done` is 0, every pixel level equals the top level TOP_LVL (default 200), and every time and stop flag is 0.
- R2: A `start` pulse taken while idle puts every pixel back at TOP_LVL. Integration cycles then begin on the next clock, and reported times count integration cycles from 1.
- R3: On each integration cycle of an open block, a pixel level drops by that pixel's `cur_in` sample. It clamps at 0 and never wraps.
- R4: `col_link` bit c joins column c with column c+1, and `row_link` bit r joins row r with row r+1. Blocks are the rectangles these links form, and both vectors are captured on the accepted `start`; later changes have no effect on the frame.
- R5: A block of N pixels freezes at the end of the first cycle on which the sum of all its pixels' samples since start reaches N*TOP_LVL/2. All its pixels stop on that cycle and then hold their levels.
- R6: A block still open on integration cycle `tmax` (with 0 treated as 1) is frozen on that cycle with stop flag 1. If the mid-range test is met on that same cycle, the flag is 0.
- R7: `blk_time` for a pixel gives the integration-cycle count of its block, and `blk_tmo` gives its stop flag (1 = limit, 0 = mid-range).
- R8: `done` rises on the clock on which the last block freezes, so the number of cycles from start to `done` equals the longest block time. It stays high until the next accepted start.
- R9: A `start` pulse during integration is ignored, and the running frame completes unchanged.
- R10: In a block with constant samples, a pixel whose sample is twice the block mean reaches exactly 0 on the freeze cycle. Brighter pixels sit clamped at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (taken only while idle) |
| col_link | input | COLS-1 | Join bits for adjacent column pairs |
| row_link | input | ROWS-1 | Join bits for adjacent row pairs |
| tmax | input | TW | Maximum integration cycles (0 acts as 1) |
| cur_in | input | ROWS*COLS*IW | Per-pixel current samples, pixel r*COLS+c at slice index r*COLS+c |
| pix_val | output | ROWS*COLS*PW | Frozen pixel levels |
| blk_time | output | ROWS*COLS*TW | Integration cycles of each pixel's block |
| blk_tmo | output | ROWS*COLS | 1 when the pixel's block stopped on the limit |
| done | output | 1 | All blocks frozen |

## Verification
The hardest case to reach from the ports is one where the mid-range test and the cycle limit fall on the same cycle, and where a start pulse arrives while a frame is still running. The stimulus reaches the first case with directed frames. There, single-pixel blocks draw a current that crosses mid-range exactly on the limit cycle. A long all-timeout frame receives a second start with different link values partway through. Frames with random links, currents and limits, with the link inputs scrambled right after start, cover uneven block shapes and clamping.

// File: rtl/exp_ctl_pkg.sv
package exp_ctl_pkg;
  typedef enum logic {
    STOP_LEVEL   = 1'b0,
    STOP_TIMEOUT = 1'b1
  } stop_e;
endpackage

// File: rtl/exp_partition.sv
module exp_partition #(
  parameter int COLS = 4,
  parameter int ROWS = 4,
  parameter int NPIX = COLS * ROWS,
  parameter int IDXW = $clog2(NPIX),
  parameter int NW   = $clog2(NPIX + 1)
) (
  input  logic [COLS-2:0]                col_lk,
  input  logic [ROWS-2:0]                row_lk,
  output logic [NPIX-1:0][IDXW-1:0]      lead_idx,
  output logic [NPIX-1:0]                is_lead,
  output logic [NPIX-1:0][NW-1:0]        bsize
);
  int c_st [COLS];
  int c_en [COLS];
  int r_st [ROWS];
  int r_en [ROWS];

  // R4: segment bounds along each axis from the link bits
  always_comb begin
    c_st[0] = 0;
    for (int c = 1; c < COLS; c++) c_st[c] = col_lk[c-1] ? c_st[c-1] : c;
    c_en[COLS-1] = COLS - 1;
    for (int c = COLS - 2; c >= 0; c--) c_en[c] = col_lk[c] ? c_en[c+1] : c;
    r_st[0] = 0;
    for (int r = 1; r < ROWS; r++) r_st[r] = row_lk[r-1] ? r_st[r-1] : r;
    r_en[ROWS-1] = ROWS - 1;
    for (int r = ROWS - 2; r >= 0; r--) r_en[r] = row_lk[r] ? r_en[r+1] : r;
  end

  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        lead_idx[r*COLS+c] = IDXW'(r_st[r] * COLS + c_st[c]);
        is_lead[r*COLS+c]  = (r_st[r] == r) && (c_st[c] == c);
        bsize[r*COLS+c]    = NW'((r_en[r] - r_st[r] + 1) * (c_en[c] - c_st[c] + 1));
      end
    end
  end
endmodule

// File: rtl/exp_block_unit.sv
module exp_block_unit
  import exp_ctl_pkg::*;
#(
  parameter int AW = 12,
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_acc,
  input  logic          busy,
  input  logic          is_lead,
  input  logic [AW-1:0] add,
  input  logic [AW-1:0] thr,
  input  logic [TW-1:0] k,
  input  logic [TW-1:0] tlim,
  output logic          frz,
  output logic          frz_nx,
  output stop_e         why_nx
);
  logic [AW-1:0] acc;
  logic [AW-1:0] acc_nx;
  logic          hit;
  logic          run;

  assign run    = busy & is_lead & ~frz;
  assign acc_nx = acc + add;
  assign hit    = (acc_nx >= thr);
  assign frz_nx = frz | (run & (hit | (k >= tlim)));
  assign why_nx = hit ? STOP_LEVEL : STOP_TIMEOUT;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      frz <= 1'b1;
    end else if (start_acc) begin
      acc <= '0;
      frz <= 1'b0;
    end else if (run) begin
      acc <= acc_nx;
      frz <= frz_nx;
    end
  end

  // R5: reaching the charge threshold closes the block on the next edge
  a_r5_level_freeze: assert property (@(posedge clk) disable iff (rst)
    (run && hit && !start_acc) |=> frz);
  // R6: the limit cycle always closes an open block
  a_r6_limit_freeze: assert property (@(posedge clk) disable iff (rst)
    (run && (k >= tlim) && !start_acc) |=> frz);
  // R5: a closed block collects no more charge
  a_r5_acc_hold: assert property (@(posedge clk) disable iff (rst)
    (frz && !start_acc) |=> $stable(acc));
endmodule

// File: rtl/exp_pixel_cell.sv
module exp_pixel_cell
  import exp_ctl_pkg::*;
#(
  parameter int PW      = 8,
  parameter int IW      = 4,
  parameter int TW      = 12,
  parameter int TOP_LVL = 200
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_acc,
  input  logic          run,
  input  logic          frz_nx,
  input  stop_e         why_nx,
  input  logic [IW-1:0] cur,
  input  logic [TW-1:0] k,
  output logic [PW-1:0] val,
  output logic [TW-1:0] tim,
  output logic          tmo
);
  logic [PW-1:0] cur_w;
  assign cur_w = PW'(cur);

  always_ff @(posedge clk) begin
    if (rst || start_acc) begin
      val <= PW'(TOP_LVL);
      tim <= '0;
      tmo <= 1'b0;
    end else if (run) begin
      val <= (cur_w >= val) ? '0 : val - cur_w;
      if (frz_nx) begin
        tim <= k;
        tmo <= (why_nx == STOP_TIMEOUT);
      end
    end
  end

  // R3: a drop larger than the level lands on zero, never wraps
  a_r3_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (run && !start_acc && (cur_w >= val)) |=> (val == '0));
  // R5: outside integration the level holds
  a_r5_hold_frozen: assert property (@(posedge clk) disable iff (rst)
    (!run && !start_acc) |=> $stable(val));
endmodule

// File: rtl/exp_block_ctl.sv
module exp_block_ctl
  import exp_ctl_pkg::*;
#(
  parameter int COLS    = 4,
  parameter int ROWS    = 4,
  parameter int PW      = 8,
  parameter int TOP_LVL = 200,
  parameter int IW      = 4,
  parameter int TW      = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [COLS-2:0]           col_link,
  input  logic [ROWS-2:0]           row_link,
  input  logic [TW-1:0]             tmax,
  input  logic [COLS*ROWS*IW-1:0]   cur_in,
  output logic [COLS*ROWS*PW-1:0]   pix_val,
  output logic [COLS*ROWS*TW-1:0]   blk_time,
  output logic [COLS*ROWS-1:0]      blk_tmo,
  output logic                      done
);
  localparam int NPIX = COLS * ROWS;
  localparam int IDXW = $clog2(NPIX);
  localparam int NW   = $clog2(NPIX + 1);
  localparam int HALF = TOP_LVL / 2;
  localparam int AW   = $clog2(NPIX * HALF + NPIX * (2 ** IW)) + 1;

  logic                   busy;
  logic [COLS-2:0]        col_q;
  logic [ROWS-2:0]        row_q;
  logic [TW-1:0]          tlim_q;
  logic [TW-1:0]          cyc;
  logic [TW-1:0]          k;
  logic                   start_acc;
  logic                   all_nx;

  logic [NPIX-1:0][IDXW-1:0] lead_idx;
  logic [NPIX-1:0]           is_lead;
  logic [NPIX-1:0][NW-1:0]   bsize;
  logic [NPIX-1:0][AW-1:0]   add;
  logic [NPIX-1:0]           frz;
  logic [NPIX-1:0]           frz_nx;
  stop_e                     why_nx [NPIX];

  assign start_acc = start & ~busy;
  assign k         = cyc + 1'b1;
  assign all_nx    = &(frz_nx | ~is_lead);

  exp_partition #(.COLS(COLS), .ROWS(ROWS), .NPIX(NPIX), .IDXW(IDXW), .NW(NW)) u_part (
    .col_lk   (col_q),
    .row_lk   (row_q),
    .lead_idx (lead_idx),
    .is_lead  (is_lead),
    .bsize    (bsize)
  );

  // per-block charge drawn this cycle
  always_comb begin
    for (int b = 0; b < NPIX; b++) begin
      add[b] = '0;
      for (int p = 0; p < NPIX; p++)
        if (int'(lead_idx[p]) == b) add[b] = add[b] + AW'(cur_in[p*IW +: IW]);
    end
  end

  for (genvar g = 0; g < NPIX; g++) begin : g_cell
    logic [AW-1:0] thr;
    assign thr = AW'(bsize[g]) * AW'(HALF);

    exp_block_unit #(.AW(AW), .TW(TW)) u_blk (
      .clk       (clk),
      .rst       (rst),
      .start_acc (start_acc),
      .busy      (busy),
      .is_lead   (is_lead[g]),
      .add       (add[g]),
      .thr       (thr),
      .k         (k),
      .tlim      (tlim_q),
      .frz       (frz[g]),
      .frz_nx    (frz_nx[g]),
      .why_nx    (why_nx[g])
    );

    exp_pixel_cell #(.PW(PW), .IW(IW), .TW(TW), .TOP_LVL(TOP_LVL)) u_pix (
      .clk       (clk),
      .rst       (rst),
      .start_acc (start_acc),
      .run       (busy & ~frz[lead_idx[g]]),
      .frz_nx    (frz_nx[lead_idx[g]]),
      .why_nx    (why_nx[lead_idx[g]]),
      .cur       (cur_in[g*IW +: IW]),
      .k         (k),
      .val       (pix_val[g*PW +: PW]),
      .tim       (blk_time[g*TW +: TW]),
      .tmo       (blk_tmo[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      cyc    <= '0;
      col_q  <= '0;
      row_q  <= '0;
      tlim_q <= TW'(1);
    end else if (start_acc) begin
      busy   <= 1'b1;
      done   <= 1'b0;
      cyc    <= '0;
      col_q  <= col_link;
      row_q  <= row_link;
      tlim_q <= (tmax == '0) ? TW'(1) : tmax;
    end else if (busy) begin
      cyc <= k;
      if (all_nx) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  // R8: done only while idle
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R6: the cycle count never passes the limit
  a_r6_cycle_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cyc < tlim_q));
  // R9: a start during integration leaves the captured partition alone
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(col_q) && $stable(row_q) && $stable(tlim_q)));
endmodule

// File: tb/sim_exp_block_ctl.sv
module sim_exp_block_ctl;
  localparam int COLS = 4;
  localparam int ROWS = 4;
  localparam int NPIX = COLS * ROWS;
  localparam int PW   = 8;
  localparam int TOP  = 200;
  localparam int IW   = 4;
  localparam int TW   = 12;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 start = 1'b0;
  logic [COLS-2:0]      col_link = '0;
  logic [ROWS-2:0]      row_link = '0;
  logic [TW-1:0]        tmax = '0;
  logic [NPIX*IW-1:0]   cur_in = '0;
  logic [NPIX*PW-1:0]   pix_val;
  logic [NPIX*TW-1:0]   blk_time;
  logic [NPIX-1:0]      blk_tmo;
  logic                 done;

  int checks = 0;
  int errors = 0;
  int curv [NPIX];
  int ev [NPIX];
  int et [NPIX];
  int ef [NPIX];
  int emax;

  always #2.5 clk = ~clk;

  exp_block_ctl #(.COLS(COLS), .ROWS(ROWS), .PW(PW), .TOP_LVL(TOP), .IW(IW), .TW(TW)) u0 (
    .clk(clk), .rst(rst), .start(start), .col_link(col_link), .row_link(row_link),
    .tmax(tmax), .cur_in(cur_in), .pix_val(pix_val), .blk_time(blk_time),
    .blk_tmo(blk_tmo), .done(done)
  );

  task automatic check(input string tag, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  // expected results from the requirements, links and limit as captured at start
  task automatic model(input logic [COLS-2:0] cl, input logic [ROWS-2:0] rl, input int tm);
    int tl;
    tl = (tm == 0) ? 1 : tm;
    emax = 0;
    for (int p = 0; p < NPIX; p++) begin
      int r0, r1, c0, c1, bsum, n, kk;
      r0 = p / COLS; r1 = r0; c0 = p % COLS; c1 = c0;
      while (c0 > 0 && cl[c0-1]) c0--;
      while (c1 < COLS - 1 && cl[c1]) c1++;
      while (r0 > 0 && rl[r0-1]) r0--;
      while (r1 < ROWS - 1 && rl[r1]) r1++;
      n = (r1 - r0 + 1) * (c1 - c0 + 1);
      bsum = 0;
      for (int r = r0; r <= r1; r++)
        for (int c = c0; c <= c1; c++) bsum += curv[r*COLS+c];
      kk = 1;
      while (kk < tl && kk * bsum < n * (TOP / 2)) kk++;
      et[p] = kk;
      ef[p] = (kk * bsum >= n * (TOP / 2)) ? 0 : 1;
      ev[p] = (TOP - kk * curv[p] < 0) ? 0 : TOP - kk * curv[p];
      if (kk > emax) emax = kk;
    end
  endtask

  task automatic run_frame(input string name, input logic [COLS-2:0] cl, input logic [ROWS-2:0] rl,
                           input int tm, input bit scramble, input bit restart_mid);
    int n;
    for (int p = 0; p < NPIX; p++) cur_in[p*IW +: IW] = IW'(curv[p]);
    col_link = cl; row_link = rl; tmax = TW'(tm);
    model(cl, rl, tm);
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    if (scramble) begin
      // R4: link and limit inputs after start must not matter
      col_link = ~cl; row_link = ~rl; tmax = TW'(tm + 7);
    end
    n = 0;
    while (!done && n < 5000) begin
      @(posedge clk); @(negedge clk); n++;
      if (restart_mid && n == 2) begin
        start = 1'b1; col_link = ~cl; row_link = ~rl;
      end else start = 1'b0;
    end
    start = 1'b0;
    check({name, " R2 R8 R9 cycles to done"}, n, emax);
    for (int p = 0; p < NPIX; p++) begin
      check({name, " R3 R5 R10 pixel level"}, int'(pix_val[p*PW +: PW]), ev[p]);
      check({name, " R7 R5 block time"}, int'(blk_time[p*TW +: TW]), et[p]);
      check({name, " R6 R7 stop flag"}, int'(blk_tmo[p]), ef[p]);
    end
    @(negedge clk);
    check({name, " R8 done held"}, int'(done), 1);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 done after reset", int'(done), 0);
    for (int p = 0; p < NPIX; p++) begin
      check("R1 pixel level after reset", int'(pix_val[p*PW +: PW]), TOP);
      check("R1 time after reset", int'(blk_time[p*TW +: TW]), 0);
      check("R1 flag after reset", int'(blk_tmo[p]), 0);
    end

    // single-pixel blocks, limit 20: cur 5 meets mid-range on the limit cycle (R6 tie)
    for (int p = 0; p < NPIX; p++) curv[p] = (p % 4 == 0) ? 5 : (p % 4 == 1) ? 0 : (p % 4 == 2) ? 15 : 9;
    run_frame("single", 3'b000, 3'b000, 20, 1'b0, 1'b0);

    // R10: twice-mean pixel reaches zero exactly; row 1 has a saturating pixel
    for (int p = 0; p < NPIX; p++) curv[p] = 0;
    curv[0] = 10; curv[1] = 0; curv[2] = 15; curv[3] = 3;
    curv[4] = 15; curv[5] = 1; curv[6] = 1; curv[7] = 1;
    run_frame("twice_mean", 3'b001, 3'b000, 100, 1'b0, 1'b0);
    run_frame("row_join", 3'b111, 3'b000, 100, 1'b0, 1'b0);

    // R6: limit of zero acts as one
    for (int p = 0; p < NPIX; p++) curv[p] = 15;
    run_frame("tmax_zero", 3'b000, 3'b000, 0, 1'b0, 1'b0);

    // R9: start during a long all-timeout frame
    for (int p = 0; p < NPIX; p++) curv[p] = 1;
    run_frame("restart_ignored", 3'b111, 3'b111, 40, 1'b0, 1'b1);

    // random frames with scrambled inputs after start (R4)
    for (int f = 0; f < 25; f++) begin
      logic [COLS-2:0] cl;
      logic [ROWS-2:0] rl;
      for (int p = 0; p < NPIX; p++) curv[p] = int'($urandom % 16);
      cl = (COLS-1)'($urandom);
      rl = (ROWS-1)'($urandom);
      run_frame("random", cl, rl, 1 + int'($urandom % 60), 1'b1, 1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule